// File: doc/BRIEF.md
# Event Counter Bank with Overflow Interrupt

The block holds a set of 32-bit event counters and one 32-bit cycle counter. Software maps the whole set through a simple register bus. Each event counter has a type register that binds it to an 8-bit event number. That register can also make the counter skip events raised at privilege level 0 or at privilege level 1. When an event report arrives with an id and an increment, the increment is added to every enabled counter subscribed to that id. The cycle counter adds one for each cycle tick.

A counter that wraps sets a sticky overflow flag. Any flag whose interrupt enable is set drives a level interrupt output. The counter enables and the interrupt enables are each written through a pair of registers: one sets the bits written as one, the other clears them. Overflow flags are cleared by writing a one to them. Software can also raise the software-increment event on chosen counters directly. A global enable gates all counting.

Byte offsets on `addr_i` select the registers. The cycle counter sits at counter index 31, so bit 31 of every mask register belongs to it.

Top module: `evt_ctr_bank`

## Requirements
- R1: After reset all counters, enable masks and overflow flags are zero and `irq_o` is low. Control (0xE04) reads 0x0000F800: the global enable is bit 0 and the counter count 31 is in bits 15:11. Configuration (0xE00) reads 0x0008DF1F: count in bits 7:0, size code 0x1F in bits 13:8, and ones in bits 14, 15 and 19.
- R2: Event counter n (0..30) is read and written at offset 4n. The cycle counter reads at 0x07C, and bus writes to 0x07C are ignored.
- R3: The type register of counter n is at 0x400+4n. Bits 7:0 hold the event number, bit 30 is the ignore-PL0 flag and bit 31 is the ignore-PL1 flag. All other bits read as zero.
- R4: A valid event report adds its increment to every counter that has its enable bit set and whose event number equals the report id. All other counters are unchanged. The new value is readable from the next cycle.
- R5: A report with `evt_pl_i`=0 skips counters with bit 30 set in their type register. A report with `evt_pl_i`=1 skips counters with bit 31 set.
- R6: While control bit 0 is clear, event reports, software increments and cycle ticks change no counter.
- R7: Writing ones to 0xC00 sets count-enable bits and writing ones to 0xC20 clears them. Writing ones to 0xC40 sets interrupt-enable bits and writing ones to 0xC60 clears them. Each set/clear pair reads back the same current mask.
- R8: With the global enable and count-enable bit 31 set, the cycle counter adds one for each cycle in which `cyc_tick_i` is high.
- R9: When the 33-bit sum of a counter and its increment carries out, the counter keeps the low 32 bits and its overflow flag (bit n of 0xC80) is set. The flag stays set until a one is written to that bit of 0xC80.
- R10: `irq_o` is high exactly when some overflow flag and the matching interrupt-enable bit are both set.
- R11: Writing a one to bit n of 0xCA0 adds one to counter n if the global enable and count-enable bit n are set. Counters whose bit is zero, or whose enable is clear, are unchanged.
- R12: Bit 16 of the configuration register is writable and reads back the last value written. The other configuration bits ignore writes.
- R13: Read data appears on `rdata_o` in the cycle after `rd_en_i`, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 12 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| evt_valid_i | input | 1 | Event report valid |
| evt_id_i | input | EVT_W | Event number of the report |
| evt_inc_i | input | INC_W | Increment carried by the report |
| evt_pl_i | input | 1 | Privilege level of the report (0 or 1) |
| cyc_tick_i | input | 1 | Cycle counter tick |
| irq_o | output | 1 | Level overflow interrupt |

## Verification
A wrong match, filter or enable decision leaves a counter off by exactly one increment. This shows up on the next read of that counter, so the bench rereads every counter after the random phase. A lost or spurious overflow flag shows on `irq_o` one cycle after the event, provided that counter's interrupt is enabled. The bench therefore compares `irq_o` with its model after every operation. A flag that fails to clear or an enable mask that is corrupted shows on the next readback of 0xC80, 0xC00 or 0xC40.

// File: rtl/evt_ctr_pkg.sv
package evt_ctr_pkg;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned ADDR_W  = 12;
  localparam int unsigned CYC_IDX = 31;

  localparam logic [ADDR_W-1:0] OFS_CYC      = 12'h07C;
  localparam logic [ADDR_W-1:0] OFS_CENA_SET = 12'hC00;
  localparam logic [ADDR_W-1:0] OFS_CENA_CLR = 12'hC20;
  localparam logic [ADDR_W-1:0] OFS_IENA_SET = 12'hC40;
  localparam logic [ADDR_W-1:0] OFS_IENA_CLR = 12'hC60;
  localparam logic [ADDR_W-1:0] OFS_OVF      = 12'hC80;
  localparam logic [ADDR_W-1:0] OFS_SWINC    = 12'hCA0;
  localparam logic [ADDR_W-1:0] OFS_CFG      = 12'hE00;
  localparam logic [ADDR_W-1:0] OFS_CTRL     = 12'hE04;

  localparam logic [4:0] REGION_CNT  = 5'h00;
  localparam logic [4:0] REGION_TYPE = 5'h08;
  localparam logic [5:0] SIZE_CODE   = 6'b011111;

  function automatic logic [BUS_W-1:0] impl_mask(int unsigned n);
    logic [BUS_W-1:0] m;
    m = '0;
    for (int i = 0; i < BUS_W; i++) if (i < n || i == CYC_IDX) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/evt_ctr_slice.sv
module evt_ctr_slice import evt_ctr_pkg::*; #(
  parameter int unsigned EVT_W = 8,
  parameter int unsigned INC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic             cnt_we_i,
  input  logic             type_we_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic             evt_valid_i,
  input  logic [EVT_W-1:0] evt_id_i,
  input  logic [INC_W-1:0] evt_inc_i,
  input  logic             evt_pl_i,
  input  logic             swinc_i,
  output logic [BUS_W-1:0] cnt_o,
  output logic [BUS_W-1:0] type_o,
  output logic             ovf_o
);
  localparam int unsigned SUM_W = BUS_W + 1;
  localparam int unsigned PAD_W = BUS_W - 2 - EVT_W;

  logic [BUS_W-1:0] cnt_q;
  logic [EVT_W-1:0] sel_q;
  logic             ign0_q, ign1_q;
  logic             match, bump;
  logic [SUM_W-1:0] add, sum;

  assign match = evt_valid_i && (evt_id_i == sel_q) && !(evt_pl_i ? ign1_q : ign0_q);
  assign add   = (match ? SUM_W'(evt_inc_i) : '0) + SUM_W'(swinc_i);
  assign sum   = {1'b0, cnt_q} + add;
  assign bump  = cnt_en_i && (match || swinc_i) && !cnt_we_i;
  assign ovf_o = bump && sum[BUS_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sel_q  <= '0;
      ign0_q <= 1'b0;
      ign1_q <= 1'b0;
    end else begin
      if (cnt_we_i) cnt_q <= wdata_i;
      else if (bump) cnt_q <= sum[BUS_W-1:0];
      if (type_we_i) begin
        sel_q  <= wdata_i[EVT_W-1:0];
        ign0_q <= wdata_i[30];
        ign1_q <= wdata_i[31];
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign type_o = {ign1_q, ign0_q, {PAD_W{1'b0}}, sel_q};
endmodule

// File: rtl/evt_ctr_cycle.sv
module evt_ctr_cycle import evt_ctr_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_en_i,
  output logic [BUS_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [BUS_W-1:0] cnt_q;

  assign ovf_o = tick_en_i && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (tick_en_i) cnt_q <= cnt_q + BUS_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/evt_ctr_bank.sv
module evt_ctr_bank import evt_ctr_pkg::*; #(
  parameter int unsigned NUM_CNT = 31,
  parameter int unsigned EVT_W   = 8,
  parameter int unsigned INC_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic              evt_valid_i,
  input  logic [EVT_W-1:0]  evt_id_i,
  input  logic [INC_W-1:0]  evt_inc_i,
  input  logic              evt_pl_i,
  input  logic              cyc_tick_i,
  output logic              irq_o
);
  localparam logic [BUS_W-1:0] IMPL = impl_mask(NUM_CNT);

  logic [BUS_W-1:0] cnt_q  [CYC_IDX];
  logic [BUS_W-1:0] type_q [CYC_IDX];
  logic [BUS_W-1:0] cyc_cnt;
  logic [BUS_W-1:0] cnt_ena, int_ena, ovf_flag, ovf_set, rd_val;
  logic             glb_en, export_q;
  logic [4:0]       idx;
  logic             in_cnt, in_type, swinc_wr;

  assign idx      = addr_i[6:2];
  assign in_cnt   = addr_i[11:7] == REGION_CNT;
  assign in_type  = addr_i[11:7] == REGION_TYPE;
  assign swinc_wr = wr_en_i && (addr_i == OFS_SWINC);

  for (genvar n = 0; n < CYC_IDX; n++) begin : g_ctr
    if (n < NUM_CNT) begin : g_on
      evt_ctr_slice #(.EVT_W(EVT_W), .INC_W(INC_W)) u_slice (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cnt_en_i   (glb_en && cnt_ena[n]),
        .cnt_we_i   (wr_en_i && in_cnt && (idx == 5'(n))),
        .type_we_i  (wr_en_i && in_type && (idx == 5'(n))),
        .wdata_i    (wdata_i),
        .evt_valid_i(evt_valid_i),
        .evt_id_i   (evt_id_i),
        .evt_inc_i  (evt_inc_i),
        .evt_pl_i   (evt_pl_i),
        .swinc_i    (swinc_wr && wdata_i[n]),
        .cnt_o      (cnt_q[n]),
        .type_o     (type_q[n]),
        .ovf_o      (ovf_set[n])
      );
    end else begin : g_off
      assign cnt_q[n]   = '0;
      assign type_q[n]  = '0;
      assign ovf_set[n] = 1'b0;
    end
  end

  evt_ctr_cycle u_cycle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_en_i(glb_en && cnt_ena[CYC_IDX] && cyc_tick_i),
    .cnt_o    (cyc_cnt),
    .ovf_o    (ovf_set[CYC_IDX])
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_ena  <= '0;
      int_ena  <= '0;
      ovf_flag <= '0;
      glb_en   <= 1'b0;
      export_q <= 1'b0;
    end else begin
      if (wr_en_i && addr_i == OFS_CENA_SET) cnt_ena <= cnt_ena | (wdata_i & IMPL);
      if (wr_en_i && addr_i == OFS_CENA_CLR) cnt_ena <= cnt_ena & ~wdata_i;
      if (wr_en_i && addr_i == OFS_IENA_SET) int_ena <= int_ena | (wdata_i & IMPL);
      if (wr_en_i && addr_i == OFS_IENA_CLR) int_ena <= int_ena & ~wdata_i;
      // a new overflow wins over a same-cycle clear
      ovf_flag <= (ovf_flag & ~((wr_en_i && addr_i == OFS_OVF) ? wdata_i : '0)) | ovf_set;
      if (wr_en_i && addr_i == OFS_CTRL) glb_en   <= wdata_i[0];
      if (wr_en_i && addr_i == OFS_CFG)  export_q <= wdata_i[16];
    end
  end

  always_comb begin
    rd_val = '0;
    if (in_cnt) begin
      if (idx == 5'(CYC_IDX)) rd_val = cyc_cnt;
      else if (32'(idx) < NUM_CNT) rd_val = cnt_q[idx];
    end else if (in_type) begin
      if (32'(idx) < NUM_CNT) rd_val = type_q[idx];
    end else begin
      case (addr_i)
        OFS_CENA_SET, OFS_CENA_CLR: rd_val = cnt_ena;
        OFS_IENA_SET, OFS_IENA_CLR: rd_val = int_ena;
        OFS_OVF:  rd_val = ovf_flag;
        OFS_CFG:  rd_val = {12'b0, 1'b1, 2'b0, export_q, 1'b1, 1'b1, SIZE_CODE, 8'(NUM_CNT)};
        OFS_CTRL: rd_val = {16'b0, 5'(NUM_CNT), 10'b0, glb_en};
        default:  rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_val;
  end

  assign irq_o = |(ovf_flag & int_ena);
endmodule

// File: rtl/evt_ctr_bank_chk.sv
module evt_ctr_bank_chk import evt_ctr_pkg::*; (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [BUS_W-1:0]  rdata_o,
  input logic              irq_o,
  input logic              cyc_tick_i,
  input logic              glb_en,
  input logic [BUS_W-1:0]  cnt_ena,
  input logic [BUS_W-1:0]  ovf_flag,
  input logic [BUS_W-1:0]  ovf_set,
  input logic [BUS_W-1:0]  cyc_cnt
);
  assert_irq_fall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(wr_en_i && (addr_i == OFS_OVF || addr_i == OFS_IENA_CLR)));

  assert_irq_rise_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past((|ovf_set) || (wr_en_i && addr_i == OFS_IENA_SET)));

  assert_ovf_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == OFS_OVF) |=> (($past(ovf_flag) & ~ovf_flag) == '0));

  assert_cyc_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_en |=> $stable(cyc_cnt));

  assert_cyc_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (glb_en && cnt_ena[CYC_IDX] && cyc_tick_i) |=> (cyc_cnt == $past(cyc_cnt) + BUS_W'(1)));

  assert_swinc_reads_zero_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == OFS_SWINC) |=> (rdata_o == '0));
endmodule

bind evt_ctr_bank evt_ctr_bank_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .rd_en_i   (rd_en_i),
  .addr_i    (addr_i),
  .rdata_o   (rdata_o),
  .irq_o     (irq_o),
  .cyc_tick_i(cyc_tick_i),
  .glb_en    (glb_en),
  .cnt_ena   (cnt_ena),
  .ovf_flag  (ovf_flag),
  .ovf_set   (ovf_set),
  .cyc_cnt   (cyc_cnt)
);

// File: tb/test_evt_ctr_bank.sv
`timescale 1ns/1ps
module test_evt_ctr_bank;
  localparam logic [11:0] A_CENA_S = 12'hC00, A_CENA_C = 12'hC20;
  localparam logic [11:0] A_IENA_S = 12'hC40, A_IENA_C = 12'hC60;
  localparam logic [11:0] A_OVF = 12'hC80, A_SWINC = 12'hCA0;
  localparam logic [11:0] A_CFG = 12'hE00, A_CTRL = 12'hE04, A_CYC = 12'h07C;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, evt_valid = 1'b0, evt_pl = 1'b0, cyc_tick = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [7:0]  evt_id = '0;
  logic [15:0] evt_inc = '0;
  logic        irq;

  int n_chk = 0, n_fail = 0;

  logic [31:0] m_cnt [32];
  logic [31:0] m_typ [31];
  logic [31:0] m_cena, m_iena, m_ovf;
  logic        m_glb, m_exp;

  always #2 clk = ~clk;

  evt_ctr_bank i_evt_ctr_bank (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_valid_i(evt_valid), .evt_id_i(evt_id),
    .evt_inc_i(evt_inc), .evt_pl_i(evt_pl), .cyc_tick_i(cyc_tick), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic exp_irq();
    return |(m_ovf & m_iena);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    if (a[11:7] == 5'h00) return m_cnt[a[6:2]];
    if (a[11:7] == 5'h08) return (a[6:2] < 31) ? m_typ[a[6:2]] : 32'h0;
    case (a)
      A_CENA_S, A_CENA_C: return m_cena;
      A_IENA_S, A_IENA_C: return m_iena;
      A_OVF:  return m_ovf;
      A_CFG:  return 32'h0008DF1F | (32'(m_exp) << 16);
      A_CTRL: return 32'h0000F800 | 32'(m_glb);
      default: return 32'h0;
    endcase
  endfunction

  function automatic void m_add(input int n, input logic [31:0] inc);
    logic [32:0] s;
    s = {1'b0, m_cnt[n]} + {1'b0, inc};
    if (s[32]) m_ovf[n] = 1'b1;
    m_cnt[n] = s[31:0];
  endfunction

  task automatic do_wr(input logic [11:0] a, input logic [31:0] d);
    if (a[11:7] == 5'h00 && a[6:2] < 31) m_cnt[a[6:2]] = d;
    if (a[11:7] == 5'h08 && a[6:2] < 31) m_typ[a[6:2]] = d & 32'hC00000FF;
    case (a)
      A_CENA_S: m_cena = m_cena | d;
      A_CENA_C: m_cena = m_cena & ~d;
      A_IENA_S: m_iena = m_iena | d;
      A_IENA_C: m_iena = m_iena & ~d;
      A_OVF:    m_ovf  = m_ovf & ~d;
      A_CTRL:   m_glb  = d[0];
      A_CFG:    m_exp  = d[16];
      A_SWINC: for (int n = 0; n < 31; n++) if (d[n] && m_glb && m_cena[n]) m_add(n, 32'd1);
      default: ;
    endcase
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a);
    logic [31:0] d;
    do_rd(a, d);
    check(req, d, exp_rd(a));
  endtask

  task automatic do_evt(input logic [7:0] id, input logic [15:0] inc, input logic pl);
    for (int n = 0; n < 31; n++)
      if (m_glb && m_cena[n] && m_typ[n][7:0] == id && !(pl ? m_typ[n][31] : m_typ[n][30]))
        m_add(n, 32'(inc));
    @(negedge clk); evt_valid = 1'b1; evt_id = id; evt_inc = inc; evt_pl = pl;
    @(negedge clk); evt_valid = 1'b0;
  endtask

  task automatic do_tick(input int k);
    for (int i = 0; i < k; i++)
      if (m_glb && m_cena[31]) begin
        if (&m_cnt[31]) m_ovf[31] = 1'b1;
        m_cnt[31] = m_cnt[31] + 32'd1;
      end
    @(negedge clk); cyc_tick = 1'b1;
    repeat (k) @(negedge clk);
    cyc_tick = 1'b0;
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed));
    for (int n = 0; n < 32; n++) m_cnt[n] = '0;
    for (int n = 0; n < 31; n++) m_typ[n] = '0;
    m_cena = '0; m_iena = '0; m_ovf = '0; m_glb = 1'b0; m_exp = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    check("R1 irq", 32'(irq), 32'h0);
    rd_chk("R1 ctrl", A_CTRL);
    rd_chk("R1 cfg", A_CFG);
    rd_chk("R1 cnt0", 12'h000);
    rd_chk("R1 cena", A_CENA_S);
    // R12 export flag writable, other bits not
    do_wr(A_CFG, 32'hFFFFFFFF);
    rd_chk("R12 cfg set", A_CFG);
    do_wr(A_CFG, 32'h0);
    rd_chk("R12 cfg clr", A_CFG);
    // R3 type register fields
    do_wr(12'h408, 32'hFFFFFFFF);
    rd_chk("R3 type2", 12'h408);
    check("R3 model", exp_rd(12'h408), 32'hC00000FF);
    do_wr(12'h408, 32'h0);
    // R2 counter access, cycle counter read-only
    do_wr(12'h014, 32'h12345678);
    rd_chk("R2 cnt5", 12'h014);
    do_wr(A_CYC, 32'hDEAD);
    rd_chk("R2 cyc ro", A_CYC);
    // R6 no counting while globally disabled
    do_wr(12'h400, 32'h3);
    do_wr(12'h404, 32'h3);
    do_wr(A_CENA_S, 32'h8000_0001);
    do_evt(8'h3, 16'd10, 1'b0);
    do_wr(A_SWINC, 32'h1);
    do_tick(3);
    rd_chk("R6 cnt0", 12'h000);
    rd_chk("R6 cyc", A_CYC);
    // R4 matching enabled counters only
    do_wr(A_CTRL, 32'h1);
    do_evt(8'h3, 16'd10, 1'b0);
    rd_chk("R4 cnt0", 12'h000);
    rd_chk("R4 cnt1 disabled", 12'h004);
    // R5 privilege filter
    do_wr(12'h404, 32'h4000_0003);
    do_wr(A_CENA_S, 32'h2);
    do_evt(8'h3, 16'd5, 1'b0);
    rd_chk("R5 pl0 skipped", 12'h004);
    do_evt(8'h3, 16'd5, 1'b1);
    rd_chk("R5 pl1 counted", 12'h004);
    rd_chk("R5 cnt0", 12'h000);
    // R8 cycle counter
    do_tick(7);
    rd_chk("R8 cyc", A_CYC);
    // R9 / R10 overflow and interrupt
    do_wr(12'h010, 32'hFFFFFFF0);
    do_wr(12'h410, 32'h9);
    do_wr(A_CENA_S, 32'h10);
    do_wr(A_IENA_S, 32'h10);
    check("R10 irq quiet", 32'(irq), 32'h0);
    do_evt(8'h9, 16'h20, 1'b1);
    rd_chk("R9 wrapped", 12'h010);
    rd_chk("R9 flag", A_OVF);
    check("R10 irq high", 32'(irq), 32'h1);
    do_wr(A_OVF, 32'h10);
    check("R10 irq low", 32'(irq), 32'h0);
    rd_chk("R9 flag clr", A_OVF);
    // R11 software increment
    do_wr(A_CENA_S, 32'h40);
    do_wr(A_SWINC, 32'hC0);
    rd_chk("R11 cnt6", 12'h018);
    rd_chk("R11 cnt7", 12'h01C);
    // R7 set/clear pairs
    do_wr(A_CENA_C, 32'h1);
    rd_chk("R7 cena set view", A_CENA_S);
    rd_chk("R7 cena clr view", A_CENA_C);
    do_wr(A_IENA_S, 32'h0300_0000);
    do_wr(A_IENA_C, 32'h0100_0000);
    rd_chk("R7 iena", A_IENA_C);
    // R13 read data holds after strobe
    do_rd(12'h014, d);
    @(negedge clk); @(negedge clk);
    check("R13 hold", rdata, 32'h12345678);

    // random phase
    for (int k = 0; k < 400; k++) begin
      int op;
      logic [31:0] v;
      op = $urandom_range(0, 8);
      v  = $urandom;
      case (op)
        0, 1: do_evt(8'($urandom_range(0, 3)), 16'($urandom), 1'($urandom));
        2: do_wr(A_SWINC, v & 32'h7FFFFFFF);
        3: do_wr(12'(4 * $urandom_range(0, 30)), v[0] ? (32'hFFFF0000 | v[15:0]) : v);
        4: do_wr(12'(12'h400 + 4 * $urandom_range(0, 30)), (v & 32'hC0000000) | 32'($urandom_range(0, 3)));
        5: do_wr(v[0] ? A_CENA_S : A_CENA_C, $urandom);
        6: do_wr(v[0] ? A_IENA_S : A_IENA_C, $urandom);
        7: do_wr(A_OVF, $urandom & $urandom);
        default: do_tick($urandom_range(1, 4));
      endcase
      check("R10 irq random", 32'(irq), 32'(exp_irq()));
    end
    for (int n = 0; n < 32; n++) rd_chk("R4 random counter", 12'(4 * n));
    rd_chk("R9 random flags", A_OVF);
    rd_chk("R7 random cena", A_CENA_C);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule